// File: doc/BRIEF.md
# Pointer Address Generator for Indirect Loads and Stores

This block forms data-memory addresses for load and store operations that reach memory through one of three 16-bit pointer pairs, here called X, Y and Z. A request names the pointer, one of four addressing styles, and a 6-bit unsigned offset. The block then presents the effective address for the memory access. When the style changes the pointer, it also returns the new pointer value with a write-back strobe, so the register file can store it.

The same datapath also performs a word add or word subtract of a 6-bit unsigned immediate on a 16-bit register pair. It returns the 16-bit result and the zero, carry, negative, overflow and sign flags. Every operation takes two cycles. The address and memory request appear in the first cycle after the request is accepted. The write-back and flag update appear in the second.

Top module: `ptr_addr_gen`

## Requirements
- R1: While reset is asserted, and until the first accepted request afterwards, `busy`, `mem_req`, `wb_en` and `flag_we` are low.
- R2: Plain mode (`op`=0) requests an access at the selected pointer value and asserts no write-back.
- R3: Post-increment mode (`op`=1) requests an access at the selected pointer value. In the following cycle it writes back that value plus one, modulo 2^16, with `wb_sel` equal to the pointer select.
- R4: Pre-decrement mode (`op`=2) requests an access at the selected pointer value minus one, modulo 2^16. In the following cycle it writes back that same decremented value, with `wb_sel` equal to the pointer select.
- R5: Displacement mode (`op`=3) with Y (`ptr_sel`=1) or Z (`ptr_sel`=2) requests an access at the pointer plus the zero-extended 6-bit `offset`, modulo 2^16, and asserts no write-back.
- R6: A rejected request raises neither `mem_req`, `wb_en` nor `flag_we`. A request is rejected when it is displacement mode with X (`ptr_sel`=0), when it is any memory mode with `ptr_sel`=3, or when its `op` is 6 or 7.
- R7: A request is accepted when `start` is high and `busy` is low. `busy` is then high for exactly the next two cycles. `mem_req` can be high only in the first of them, and `wb_en` and `flag_we` only in the second. `start` is ignored while `busy` is high.
- R8: Word add (`op`=4) writes back `pair_val` plus the zero-extended `offset`, modulo 2^16, with `wb_sel`=3, and raises no memory request.
- R9: Word subtract (`op`=5) writes back `pair_val` minus the zero-extended `offset`, modulo 2^16, with `wb_sel`=3, and raises no memory request.
- R10: For word operations `flag_we` is high together with `wb_en`. The flags are set as follows:
  - Z: the result is zero.
  - C: the carry out of bit 15 on add, or the borrow on subtract.
  - N: bit 15 of the result.
  - V: signed overflow of the 16-bit result.
  - S: N XOR V.

  The flag outputs keep their values between word operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe |
| op | input | 3 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement, 4 word add, 5 word subtract |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| x_ptr | input | 16 | Current X pointer value |
| y_ptr | input | 16 | Current Y pointer value |
| z_ptr | input | 16 | Current Z pointer value |
| pair_val | input | 16 | Register pair operand for word operations |
| offset | input | 6 | Displacement or immediate, unsigned |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access request, first cycle |
| mem_addr | output | 16 | Effective address, valid with mem_req |
| wb_en | output | 1 | Write-back strobe, second cycle |
| wb_sel | output | 2 | Write-back target: pointer select, or 3 for the word-operation pair |
| wb_val | output | 16 | Write-back value |
| flag_we | output | 1 | Flag update strobe |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry or borrow flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag |

## Verification
The sweep drives pointer values at 0x0000, 0x7FFF, 0x8000 and 0xFFFF together with offsets of 0 and 63:
- A design that failed to wrap modulo 2^16 would return 0x10000-style carries into the address or write-back.
- A design that applied the decrement after the access, as post-increment does, would present the undecremented pointer on a pre-decrement access.
- Displacement with X and the unused select code are checked for a silent `mem_req`. A design that treated X like Y would issue a stray access.

Word add and subtract are swept over every immediate. This exposes a carry taken from the wrong bit, a borrow reported with the wrong sense, and overflow flagged for the wrong sign transition. A start held high through a busy operation must not launch a second one. A design that accepted it would corrupt the write-back value or produce a third busy cycle.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

  typedef enum logic [2:0] {
    OP_PLAIN   = 3'd0,
    OP_POSTINC = 3'd1,
    OP_PREDEC  = 3'd2,
    OP_DISP    = 3'd3,
    OP_WADD    = 3'd4,
    OP_WSUB    = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } ptr_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DONE = 2'd2
  } ptr_phase_e;

  localparam logic [1:0] SEL_X    = 2'd0;
  localparam logic [1:0] SEL_Y    = 2'd1;
  localparam logic [1:0] SEL_Z    = 2'd2;
  localparam logic [1:0] SEL_PAIR = 2'd3;

endpackage

// File: rtl/ptr_rst_sync.sv
module ptr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ptr_addr_calc.sv
module ptr_addr_calc
  import ptr_agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int OFFW = 6
) (
  input  ptr_op_e         op,
  input  logic [1:0]      sel,
  input  logic [AW-1:0]   ptr,
  input  logic [OFFW-1:0] off,
  output logic [AW-1:0]   eff_addr,
  output logic [AW-1:0]   next_ptr,
  output logic            access_ok,
  output logic            ptr_update
);
  localparam int PADW = AW - OFFW;

  logic [AW-1:0] ptr_inc, ptr_dec, ptr_disp;
  logic          sel_valid, sel_disp_ok;

  assign ptr_inc     = ptr + AW'(1);
  assign ptr_dec     = ptr - AW'(1);
  assign ptr_disp    = ptr + {{PADW{1'b0}}, off};
  assign sel_valid   = (sel != SEL_PAIR);
  assign sel_disp_ok = (sel == SEL_Y) || (sel == SEL_Z);

  always_comb begin
    eff_addr   = ptr;
    next_ptr   = ptr;
    access_ok  = 1'b0;
    ptr_update = 1'b0;
    unique case (op)
      OP_PLAIN:   access_ok = sel_valid;
      OP_POSTINC: begin
        access_ok  = sel_valid;
        next_ptr   = ptr_inc;
        ptr_update = 1'b1;
      end
      OP_PREDEC:  begin
        access_ok  = sel_valid;
        eff_addr   = ptr_dec;
        next_ptr   = ptr_dec;
        ptr_update = 1'b1;
      end
      OP_DISP:    begin
        access_ok = sel_disp_ok;
        eff_addr  = ptr_disp;
      end
      default:    access_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptr_word_alu.sv
module ptr_word_alu #(
  parameter int AW   = 16,
  parameter int OFFW = 6
) (
  input  logic            sub,
  input  logic [AW-1:0]   a,
  input  logic [OFFW-1:0] k,
  output logic [AW-1:0]   res,
  output logic            z,
  output logic            c,
  output logic            n,
  output logic            v,
  output logic            s
);
  localparam int PADW = AW + 1 - OFFW;

  logic [AW:0] a_ext, k_ext, wide;

  assign a_ext = {1'b0, a};
  assign k_ext = {{PADW{1'b0}}, k};
  assign wide  = sub ? (a_ext - k_ext) : (a_ext + k_ext);
  assign res   = wide[AW-1:0];

  always_comb begin
    z = (res == '0);
    c = wide[AW];
    n = res[AW-1];
    if (sub) v = (a[AW-1] != k_ext[AW-1]) && (res[AW-1] != a[AW-1]);
    else     v = (a[AW-1] == k_ext[AW-1]) && (res[AW-1] != a[AW-1]);
    s = n ^ v;
  end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int OFFW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [1:0]      ptr_sel,
  input  logic [AW-1:0]   x_ptr,
  input  logic [AW-1:0]   y_ptr,
  input  logic [AW-1:0]   z_ptr,
  input  logic [AW-1:0]   pair_val,
  input  logic [OFFW-1:0] offset,
  output logic            busy,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic            wb_en,
  output logic [1:0]      wb_sel,
  output logic [AW-1:0]   wb_val,
  output logic            flag_we,
  output logic            flag_z,
  output logic            flag_c,
  output logic            flag_n,
  output logic            flag_v,
  output logic            flag_s
);
  logic rst_n_i;

  ptr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  // request stage
  ptr_phase_e      phase_q, phase_d;
  ptr_op_e         op_q, op_in;
  logic [1:0]      sel_q;
  logic [AW-1:0]   opnd_q, opnd_d;
  logic [OFFW-1:0] off_q;
  logic            accept, in_addr, is_word, word_in;

  assign op_in   = ptr_op_e'(op);
  assign accept  = start && (phase_q == PH_IDLE);
  assign in_addr = (phase_q == PH_ADDR);
  assign word_in = (op_in == OP_WADD) || (op_in == OP_WSUB);
  assign is_word = (op_q == OP_WADD) || (op_q == OP_WSUB);

  always_comb begin
    if (word_in) opnd_d = pair_val;
    else begin
      unique case (ptr_sel)
        SEL_X:   opnd_d = x_ptr;
        SEL_Y:   opnd_d = y_ptr;
        SEL_Z:   opnd_d = z_ptr;
        default: opnd_d = '0;
      endcase
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_IDLE: phase_d = accept ? PH_ADDR : PH_IDLE;
      PH_ADDR: phase_d = PH_DONE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_PLAIN;
      sel_q   <= SEL_X;
      opnd_q  <= '0;
      off_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        op_q   <= op_in;
        sel_q  <= ptr_sel;
        opnd_q <= opnd_d;
        off_q  <= offset;
      end
    end
  end

  // address and arithmetic
  logic [AW-1:0] eff_addr, next_ptr, alu_res;
  logic          access_ok, ptr_update;
  logic          a_z, a_c, a_n, a_v, a_s;

  ptr_addr_calc #(.AW(AW), .OFFW(OFFW)) u_calc (
    .op(op_q), .sel(sel_q), .ptr(opnd_q), .off(off_q),
    .eff_addr(eff_addr), .next_ptr(next_ptr),
    .access_ok(access_ok), .ptr_update(ptr_update)
  );

  ptr_word_alu #(.AW(AW), .OFFW(OFFW)) u_alu (
    .sub(op_q == OP_WSUB), .a(opnd_q), .k(off_q), .res(alu_res),
    .z(a_z), .c(a_c), .n(a_n), .v(a_v), .s(a_s)
  );

  // write-back stage
  logic          wb_en_q, wb_en_d, flag_we_q, flag_we_d;
  logic [1:0]    wb_sel_q, wb_sel_d;
  logic [AW-1:0] wb_val_q, wb_val_d;
  logic [4:0]    flags_q;

  assign wb_en_d   = in_addr && ((access_ok && ptr_update) || is_word);
  assign flag_we_d = in_addr && is_word;
  assign wb_val_d  = is_word ? alu_res : next_ptr;
  assign wb_sel_d  = is_word ? SEL_PAIR : sel_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wb_en_q   <= 1'b0;
      flag_we_q <= 1'b0;
      wb_sel_q  <= SEL_X;
      wb_val_q  <= '0;
      flags_q   <= '0;
    end else begin
      wb_en_q   <= wb_en_d;
      flag_we_q <= flag_we_d;
      if (in_addr) begin
        wb_sel_q <= wb_sel_d;
        wb_val_q <= wb_val_d;
      end
      if (flag_we_d) flags_q <= {a_z, a_c, a_n, a_v, a_s};
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign mem_req  = in_addr && access_ok;
  assign mem_addr = eff_addr;
  assign wb_en    = wb_en_q;
  assign wb_sel   = wb_sel_q;
  assign wb_val   = wb_val_q;
  assign flag_we  = flag_we_q;
  assign {flag_z, flag_c, flag_n, flag_v, flag_s} = flags_q;

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (start && !busy) |=> busy);
  // R7
  req_wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0({mem_req, wb_en}));
  // R3
  postinc_wb_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req && op_q == OP_POSTINC) |=> (wb_en && wb_val == AW'($past(mem_addr) + AW'(1))));
  // R4
  predec_wb_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req && op_q == OP_PREDEC) |=> (wb_en && wb_val == $past(mem_addr)));
  // R2 R5
  no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mem_req && (op_q == OP_PLAIN || op_q == OP_DISP)) |=> !wb_en);
  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    flag_we |-> (flag_z == (wb_val == '0)));
endmodule

// File: tb/ptr_addr_gen_test.sv
`timescale 1ns/1ps
module ptr_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [1:0]  ptr_sel;
  logic [15:0] x_ptr, y_ptr, z_ptr, pair_val;
  logic [5:0]  offset;
  logic        busy, mem_req, wb_en, flag_we;
  logic        flag_z, flag_c, flag_n, flag_v, flag_s;
  logic [15:0] mem_addr, wb_val;
  logic [1:0]  wb_sel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ptr_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ptr_sel(ptr_sel),
    .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr), .pair_val(pair_val),
    .offset(offset), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val), .flag_we(flag_we),
    .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v),
    .flag_s(flag_s)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] val_at(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'hFFC1;
      6: return 16'h003F;
      default: return 16'hA5C3;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] o, input bit legal);
    if (!legal) return "R6";
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  // one operation; called and returns at a negedge with busy low
  task automatic run_op(input logic [2:0] o, input logic [1:0] s,
                        input logic [15:0] pv, input logic [5:0] off);
    logic [15:0] p, exp_addr, exp_wb;
    logic [16:0] wide;
    bit          is_mem, is_word, legal, exp_req, exp_wbe;
    logic        ez, ec, en, ev;
    string       tg;
    x_ptr = pv; y_ptr = pv ^ 16'h5A5A; z_ptr = pv + 16'h1234; pair_val = pv;
    case (s)
      2'd0: p = x_ptr;
      2'd1: p = y_ptr;
      2'd2: p = z_ptr;
      default: p = 16'h0000;
    endcase
    is_mem  = (o <= 3'd3);
    is_word = (o == 3'd4) || (o == 3'd5);
    legal   = is_word || (is_mem && s != 2'd3 && !(o == 3'd3 && s == 2'd0));
    exp_req = is_mem && legal;
    exp_wbe = is_word || (exp_req && (o == 3'd1 || o == 3'd2));
    exp_addr = p; exp_wb = p; ez = 0; ec = 0; en = 0; ev = 0;
    case (o)
      3'd1: exp_wb = p + 16'd1;
      3'd2: begin exp_addr = p - 16'd1; exp_wb = exp_addr; end
      3'd3: exp_addr = p + {10'd0, off};
      3'd4: begin
        wide = {1'b0, pv} + {11'd0, off}; exp_wb = wide[15:0];
        ec = wide[16]; ev = !pv[15] && exp_wb[15];
      end
      3'd5: begin
        wide = {1'b0, pv} - {11'd0, off}; exp_wb = wide[15:0];
        ec = wide[16]; ev = pv[15] && !exp_wb[15];
      end
      default: ;
    endcase
    en = exp_wb[15]; ez = (exp_wb == 16'd0);
    tg = tag_of(o, legal);
    op = o; ptr_sel = s; offset = off; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // first cycle
    chk(busy === 1'b1, "R7 busy first", busy, 1);
    chk(mem_req === exp_req, tg, mem_req, exp_req);
    if (exp_req) chk(mem_addr === exp_addr, tg, mem_addr, exp_addr);
    chk(wb_en === 1'b0 && flag_we === 1'b0, "R7 no wb in first", {wb_en, flag_we}, 0);
    @(negedge clk);
    // second cycle
    chk(busy === 1'b1 && mem_req === 1'b0, "R7 second", {busy, mem_req}, 2);
    chk(wb_en === exp_wbe, tg, wb_en, exp_wbe);
    chk(flag_we === is_word, "R10 flag_we", flag_we, is_word);
    if (exp_wbe) begin
      chk(wb_val === exp_wb, tg, wb_val, exp_wb);
      chk(wb_sel === (is_word ? 2'd3 : s), tg, wb_sel, is_word ? 2'd3 : s);
    end
    if (is_word)
      chk({flag_z, flag_c, flag_n, flag_v, flag_s} === {ez, ec, en, ev, en ^ ev},
          "R10 flags", {flag_z, flag_c, flag_n, flag_v, flag_s},
          {ez, ec, en, ev, en ^ ev});
    @(negedge clk);
    chk(busy === 1'b0, "R7 idle", busy, 0);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] held;
    rst_n = 1'b0; start = 1'b0; op = '0; ptr_sel = '0; offset = '0;
    x_ptr = '0; y_ptr = '0; z_ptr = '0; pair_val = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !mem_req && !wb_en && !flag_we, "R1 in reset",
        {busy, mem_req, wb_en, flag_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req && !wb_en && !flag_we, "R1 after reset",
        {busy, mem_req, wb_en, flag_we}, 0);

    // memory modes over all selects, edge pointers and offsets
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 8; v++)
          for (int f = 0; f < 4; f++)
            run_op(3'(o), 2'(s), val_at(v),
                   (f == 0) ? 6'd0 : (f == 1) ? 6'd1 : (f == 2) ? 6'd37 : 6'd63);

    // word add and subtract, every immediate
    for (int o = 4; o < 6; o++)
      for (int v = 0; v < 8; v++)
        for (int k = 0; k < 64; k++)
          run_op(3'(o), 2'd1, val_at(v), 6'(k));

    // R6 reserved opcodes
    for (int o = 6; o < 8; o++)
      for (int s = 0; s < 4; s++)
        run_op(3'(o), 2'(s), 16'h1357, 6'd5);

    // R7 start held while busy is ignored
    x_ptr = 16'h1000; y_ptr = 16'h2FFF; z_ptr = 16'h4000; pair_val = 16'h0;
    op = 3'd1; ptr_sel = 2'd1; offset = 6'd0; start = 1'b1;
    @(negedge clk);
    op = 3'd2; ptr_sel = 2'd2; offset = 6'd9;
    chk(mem_req === 1'b1 && mem_addr === 16'h2FFF, "R7 held first", mem_addr, 16'h2FFF);
    @(negedge clk);
    chk(wb_en === 1'b1 && wb_val === 16'h3000 && wb_sel === 2'd1, "R7 held wb",
        wb_val, 16'h3000);
    start = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && mem_req === 1'b0, "R7 held idle", {busy, mem_req}, 0);

    // R10 flags persist through a memory operation
    run_op(3'd5, 2'd0, 16'h0000, 6'd1);
    held = {flag_z, flag_c, flag_n, flag_v, flag_s};
    run_op(3'd1, 2'd2, 16'h0100, 6'd0);
    chk({flag_z, flag_c, flag_n, flag_v, flag_s} === held, "R10 flags hold",
        {flag_z, flag_c, flag_n, flag_v, flag_s}, held);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule